// File: doc/BRIEF.md
# Receive Cell Buffer with Word-Serial Readout

This block holds extracted cells from two traffic directions in a single shared first-in first-out store. It keeps up to twelve complete cells. Each cell is 27 sixteen-bit words: two header words, one word with the HEC and user-defined octets, and 24 payload words. A capture port takes one word per cycle. A start-of-cell marker opens each cell, and the direction the cell came from is given with its first word. The block writes that direction into a fixed bit of the user-defined octet of the stored cell, so the reader can tell the two streams apart after they share the buffer.

A processor drains the store through one read-data register. Each read strobe returns the next word, so 27 strobes fetch one cell. A cell-available flag stays high while at least one whole cell is waiting. The flag drops by itself after the last word of the last stored cell has been read. A cell becomes visible to the reader only when its 27th word has been written. A cell that starts while the store is full is discarded whole, and a sticky overflow flag records the loss.

Top module: `rxcell_fifo`

## Requirements
- R1: The store holds up to 12 complete cells of 27 words each. Cells are read back in the order they were completed, and the words of each cell come out in the order they were captured.
- R2: In the stored copy of a cell, bit 0 of word 2 (0-based word index) is replaced by the `cap_dir` value sampled with that cell's start word. All other bits are kept as captured.
- R3: A cell is committed only when its 27th word is written. Before that, `cell_irq` does not rise for it and reads do not return its words.
- R4: A start-of-cell word that arrives while a cell is partly captured discards the partial cell. The new word becomes word 0 of a fresh cell.
- R5: A start-of-cell word that arrives while 12 cells are stored drops that whole cell, including all its following words, and sets `ovf_flag`. `ovf_flag` then stays set until reset.
- R6: A read strobe while no complete cell is stored loads zero into `rd_data` and does not advance the read position.
- R7: `rd_data` shows the word selected by a read strobe from the clock edge after the strobe. It keeps that value until the next strobe.
- R8: `cell_irq` is high on the edge after a commit makes at least one cell available. It falls on the edge of the 27th read of a cell only when no other complete cell remains, including a cell committed in that same cycle.
- R9: A captured word without start-of-cell, arriving when no cell is being captured, has no effect.
- R10: After reset, `rd_data` is zero, `cell_irq` is low, `ovf_flag` is low and the store is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_valid | input | 1 | A capture word is present this cycle |
| cap_sop | input | 1 | The capture word is word 0 of a cell |
| cap_dir | input | 1 | Direction of the cell, sampled with the start word |
| cap_data | input | 16 | Capture word |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rd_data | output | 16 | Read-data register |
| cell_irq | output | 1 | At least one complete cell is stored |
| ovf_flag | output | 1 | Sticky: a cell was dropped because the store was full |

## Verification
A read pointer that is off by even one word shows up at once on `rd_data`: every later word of that cell and of every later cell comes back shifted, and the bench compares each word as it is read. An occupancy count that is wrong makes `cell_irq` stay high, or fall, one read of 27 words early or late. It also makes the drop decision wrong on the thirteenth cell, which shows on `ovf_flag` the cycle after that cell's start word. The bench runs a cycle-accurate model in parallel and compares all three outputs every cycle, so any difference is reported in the cycle it first appears.

// File: rtl/rxcf_pkg.sv
package rxcf_pkg;
    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_FILL = 2'd1,
        WR_DROP = 2'd2
    } wr_mode_e;
endpackage

// File: rtl/rxcf_wr_ctrl.sv
module rxcf_wr_ctrl
    import rxcf_pkg::*;
#(
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned CELL_WORDS = 27,
    parameter int unsigned CELLS      = 12,
    parameter int unsigned DIR_WORD   = 2,
    parameter int unsigned DIR_BIT    = 0,
    localparam int unsigned WIDX_W    = $clog2(CELL_WORDS),
    localparam int unsigned SLOT_W    = $clog2(CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              sop_i,
    input  logic              dir_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              full_i,
    output logic              we_o,
    output logic [SLOT_W-1:0] wslot_o,
    output logic [WIDX_W-1:0] wword_o,
    output logic [WORD_W-1:0] wdata_o,
    output logic              commit_o,
    output logic              ovf_o
);
    localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(CELL_WORDS - 1);
    localparam logic [SLOT_W-1:0] LAST_S = SLOT_W'(CELLS - 1);
    localparam logic [WIDX_W-1:0] TAG_W  = WIDX_W'(DIR_WORD);

    typedef struct packed {
        wr_mode_e          mode;
        logic [WIDX_W-1:0] word;
        logic [SLOT_W-1:0] slot;
        logic              dir;
        logic              ovf;
    } wr_state_t;

    wr_state_t s_d, s_q;
    logic      dir_sel;

    always_comb begin
        s_d      = s_q;
        we_o     = 1'b0;
        commit_o = 1'b0;
        wword_o  = s_q.word;
        dir_sel  = s_q.dir;
        if (valid_i) begin
            if (sop_i) begin
                if (full_i) begin
                    s_d.mode = WR_DROP;
                    s_d.ovf  = 1'b1;
                    s_d.word = '0;
                end else begin
                    we_o     = 1'b1;
                    wword_o  = '0;
                    dir_sel  = dir_i;
                    s_d.mode = WR_FILL;
                    s_d.word = WIDX_W'(1);
                    s_d.dir  = dir_i;
                end
            end else if (s_q.mode == WR_FILL) begin
                we_o = 1'b1;
                if (s_q.word == LAST_W) begin
                    commit_o = 1'b1;
                    s_d.mode = WR_IDLE;
                    s_d.word = '0;
                    s_d.slot = (s_q.slot == LAST_S) ? '0 : s_q.slot + 1'b1;
                end else begin
                    s_d.word = s_q.word + 1'b1;
                end
            end
        end
        wdata_o = data_i;
        if (wword_o == TAG_W) begin
            wdata_o[DIR_BIT] = dir_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: WR_IDLE, word: '0, slot: '0, dir: 1'b0, ovf: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign wslot_o = s_q.slot;
    assign ovf_o   = s_q.ovf;

    assert_no_commit_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> !full_i);
    assert_fill_index_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.word <= LAST_W);
endmodule

// File: rtl/rxcf_store.sv
module rxcf_store #(
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned CELL_WORDS = 27,
    parameter int unsigned CELLS      = 12,
    localparam int unsigned WIDX_W    = $clog2(CELL_WORDS),
    localparam int unsigned SLOT_W    = $clog2(CELLS),
    localparam int unsigned DEPTH     = CELLS * CELL_WORDS,
    localparam int unsigned ADDR_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [SLOT_W-1:0] wslot_i,
    input  logic [WIDX_W-1:0] wword_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [SLOT_W-1:0] rslot_i,
    input  logic [WIDX_W-1:0] rword_i,
    output logic [WORD_W-1:0] rdata_o
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    function automatic logic [ADDR_W-1:0] flat(input logic [SLOT_W-1:0] s,
                                                input logic [WIDX_W-1:0] w);
        return ADDR_W'(s) * ADDR_W'(CELL_WORDS) + ADDR_W'(w);
    endfunction

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[flat(wslot_i, wword_i)] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[flat(rslot_i, rword_i)];
endmodule

// File: rtl/rxcf_rd_ctrl.sv
module rxcf_rd_ctrl #(
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned CELL_WORDS = 27,
    parameter int unsigned CELLS      = 12,
    localparam int unsigned WIDX_W    = $clog2(CELL_WORDS),
    localparam int unsigned SLOT_W    = $clog2(CELLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic              empty_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic [SLOT_W-1:0] rslot_o,
    output logic [WIDX_W-1:0] rword_o,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              pop_o
);
    localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(CELL_WORDS - 1);
    localparam logic [SLOT_W-1:0] LAST_S = SLOT_W'(CELLS - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [WIDX_W-1:0] word;
        logic [WORD_W-1:0] data;
    } rd_state_t;

    rd_state_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        pop_o = 1'b0;
        if (rd_en_i) begin
            if (empty_i) begin
                s_d.data = '0;
            end else begin
                s_d.data = mem_rdata_i;
                if (s_q.word == LAST_W) begin
                    pop_o    = 1'b1;
                    s_d.word = '0;
                    s_d.slot = (s_q.slot == LAST_S) ? '0 : s_q.slot + 1'b1;
                end else begin
                    s_d.word = s_q.word + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rslot_o   = s_q.slot;
    assign rword_o   = s_q.word;
    assign rd_data_o = s_q.data;

    assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && empty_i) |=> (rd_data_o == '0));
    assert_empty_read_no_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && empty_i) |=> $stable(rword_o));
    assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));
    assert_pop_needs_cell_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |-> !empty_i);
endmodule

// File: rtl/rxcell_fifo.sv
module rxcell_fifo #(
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned CELL_WORDS = 27,
    parameter int unsigned CELLS      = 12,
    parameter int unsigned DIR_WORD   = 2,
    parameter int unsigned DIR_BIT    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_valid,
    input  logic              cap_sop,
    input  logic              cap_dir,
    input  logic [WORD_W-1:0] cap_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              cell_irq,
    output logic              ovf_flag
);
    localparam int unsigned WIDX_W = $clog2(CELL_WORDS);
    localparam int unsigned SLOT_W = $clog2(CELLS);
    localparam int unsigned CNT_W  = $clog2(CELLS + 1);
    localparam logic [CNT_W-1:0] FULL_N = CNT_W'(CELLS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } occ_state_t;

    occ_state_t o_d, o_q;

    logic              we, commit, pop;
    logic [SLOT_W-1:0] wslot, rslot;
    logic [WIDX_W-1:0] wword, rword;
    logic [WORD_W-1:0] wdata, mem_rdata;

    rxcf_wr_ctrl #(
        .WORD_W(WORD_W), .CELL_WORDS(CELL_WORDS), .CELLS(CELLS),
        .DIR_WORD(DIR_WORD), .DIR_BIT(DIR_BIT)
    ) u_wr (
        .clk(clk), .rst_n(rst_n),
        .valid_i(cap_valid), .sop_i(cap_sop), .dir_i(cap_dir), .data_i(cap_data),
        .full_i(o_q.cnt == FULL_N),
        .we_o(we), .wslot_o(wslot), .wword_o(wword), .wdata_o(wdata),
        .commit_o(commit), .ovf_o(ovf_flag)
    );

    rxcf_store #(
        .WORD_W(WORD_W), .CELL_WORDS(CELL_WORDS), .CELLS(CELLS)
    ) u_store (
        .clk(clk), .we_i(we), .wslot_i(wslot), .wword_i(wword), .wdata_i(wdata),
        .rslot_i(rslot), .rword_i(rword), .rdata_o(mem_rdata)
    );

    rxcf_rd_ctrl #(
        .WORD_W(WORD_W), .CELL_WORDS(CELL_WORDS), .CELLS(CELLS)
    ) u_rd (
        .clk(clk), .rst_n(rst_n),
        .rd_en_i(rd_en), .empty_i(o_q.cnt == '0), .mem_rdata_i(mem_rdata),
        .rslot_o(rslot), .rword_o(rword), .rd_data_o(rd_data), .pop_o(pop)
    );

    always_comb begin
        o_d     = o_q;
        o_d.cnt = o_q.cnt + CNT_W'(commit) - CNT_W'(pop);
        o_d.irq = (o_d.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign cell_irq = o_q.irq;

    assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        o_q.cnt <= FULL_N);
    assert_irq_after_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cell_irq) |-> $past(commit));
    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);
    assert_irq_fall_after_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cell_irq) |-> $past(pop));
endmodule

// File: tb/rxcell_fifo_test.sv
`timescale 1ns/1ps
module rxcell_fifo_test;
    localparam int NW = 27;
    localparam int NC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_valid = 1'b0, cap_sop = 1'b0, cap_dir = 1'b0, rd_en = 1'b0;
    logic [15:0] cap_data = '0;
    logic [15:0] rd_data;
    logic        cell_irq, ovf_flag;

    always #2.5 clk = ~clk;

    rxcell_fifo uut (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_sop(cap_sop),
        .cap_dir(cap_dir), .cap_data(cap_data), .rd_en(rd_en),
        .rd_data(rd_data), .cell_irq(cell_irq), .ovf_flag(ovf_flag)
    );

    int compared = 0;
    int mismatched = 0;

    // reference model state
    logic [15:0] mq [NC][NW];
    logic [15:0] wbuf [NW];
    int   head = 0, cnt = 0, ridx = 0, widx = 0;
    bit   wact = 0, wdir = 0, e_ovf = 0;
    logic [15:0] e_rd = '0;

    function automatic logic [15:0] tag_word(input int idx, input logic [15:0] d, input bit dir);
        logic [15:0] r = d;
        if (idx == 2) r[0] = dir;
        return r;
    endfunction

    task automatic model_step(input bit v, input bit s, input bit d, input logic [15:0] dat, input bit r);
        int  old = cnt;
        bit  pop = 0, com = 0;
        int  tail = (head + old) % NC;
        if (r) begin
            if (old == 0) e_rd = '0;
            else begin
                e_rd = mq[head][ridx];
                ridx++;
                if (ridx == NW) begin ridx = 0; pop = 1; end
            end
        end
        if (v) begin
            if (s) begin
                if (old == NC) begin e_ovf = 1; wact = 0; end
                else begin wact = 1; wdir = d; wbuf[0] = tag_word(0, dat, d); widx = 1; end
            end else if (wact) begin
                wbuf[widx] = tag_word(widx, dat, wdir);
                widx++;
                if (widx == NW) begin com = 1; wact = 0; widx = 0; end
            end
        end
        if (com) for (int i = 0; i < NW; i++) mq[tail][i] = wbuf[i];
        if (pop) head = (head + 1) % NC;
        cnt = old - int'(pop) + int'(com);
    endtask

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cyc(input string req, input bit v, input bit s, input bit d,
                       input logic [15:0] dat, input bit r);
        cap_valid = v; cap_sop = s; cap_dir = d; cap_data = dat; rd_en = r;
        @(posedge clk);
        model_step(v, s, d, dat, r);
        #1;
        check(req, "rd_data", rd_data, e_rd);
        check(req, "cell_irq", {15'd0, cell_irq}, {15'd0, cnt != 0});
        check(req, "ovf_flag", {15'd0, ovf_flag}, {15'd0, e_ovf});
    endtask

    task automatic send_cell(input string req, input bit d);
        for (int i = 0; i < NW; i++) cyc(req, 1, i == 0, d, 16'($urandom), 0);
    endtask

    task automatic read_cell(input string req);
        for (int i = 0; i < NW; i++) cyc(req, 0, 0, 0, '0, 1);
    endtask

    initial begin
        #1000000;
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check("R10", "rd_data", rd_data, 16'h0);
        check("R10", "cell_irq", {15'd0, cell_irq}, 16'h0);
        check("R10", "ovf_flag", {15'd0, ovf_flag}, 16'h0);
        rst_n = 1'b1;
        cyc("R10", 0, 0, 0, '0, 0);

        // R9: stray words with no open cell, then R6: read on empty
        for (int i = 0; i < 10; i++) cyc("R9", 1, 0, i[0], 16'($urandom), 0);
        cyc("R6", 0, 0, 0, '0, 1);
        cyc("R6", 0, 0, 0, '0, 1);

        // R3: reads during fill of a cell see nothing
        for (int i = 0; i < NW; i++) cyc("R3", 1, i == 0, 1, 16'($urandom), i < 26);
        cyc("R7", 0, 0, 0, '0, 0);
        read_cell("R1");
        cyc("R8", 0, 0, 0, '0, 0);

        // R4: restart mid-cell
        for (int i = 0; i < 10; i++) cyc("R4", 1, i == 0, 0, 16'($urandom), 0);
        send_cell("R4", 1);
        read_cell("R4");

        // R2: both direction tags, with data bit 0 set opposite
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < NW; i++)
                cyc("R2", 1, i == 0, k[0], (i == 2) ? {15'h5a5a, ~k[0]} : 16'($urandom), 0);
        end
        for (int k = 0; k < 4; k++) read_cell("R2");

        // R5: fill to 12, 13th dropped whole, overflow sticks
        for (int k = 0; k < NC; k++) send_cell("R1", k[1]);
        send_cell("R5", 1);
        for (int i = 0; i < 5; i++) cyc("R5", 1, 0, 0, 16'($urandom), 0);
        for (int k = 0; k < NC; k++) read_cell("R5");
        cyc("R6", 0, 0, 0, '0, 1);

        // R8: final read of a cell together with commit of the next
        send_cell("R8", 0);
        for (int i = 0; i < NW; i++) cyc("R8", 1, i == 0, 1, 16'($urandom), 1);
        read_cell("R8");
        cyc("R8", 0, 0, 0, '0, 0);

        // R1/R7: constrained random traffic
        begin
            int pos = 0;
            for (int t = 0; t < 6000; t++) begin
                bit v = ($urandom % 4) != 0;
                bit s = 0;
                bit r = (t < 2500) ? (($urandom % 8) == 0) : (($urandom % 4) != 0);
                if (v) begin
                    if (pos == 0 || ($urandom % 300) == 0) begin s = 1; pos = 1; end
                    else begin pos = (pos == NW - 1) ? 0 : pos + 1; end
                end
                cyc("R1", v, s, 1'($urandom), 16'($urandom), r);
            end
        end
        for (int i = 0; i < NC * NW + 4; i++) cyc("R7", 0, 0, 0, '0, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule